// File: doc/BRIEF.md
# Multi-Queue Inter-Processor Mailbox

This block lets several processors exchange 32-bit words through six independent first-in first-out queues reached over a simple single-cycle register port. A processor sends a word by writing it to a queue's message address and receives one by reading the same address, which removes the oldest word. Each queue also exposes a full flag and a count of waiting words, so software can poll instead of taking an interrupt.

Four interrupt users each own a status word and an enable word. Each queue raises two events in every user's status word: one when a word is accepted and one when a removal takes the queue out of the full state. Status bits are acknowledged by writing ones. A user's interrupt line is high while any status bit is set under a set enable bit. A small config register holds two idle-mode bits, and a revision word and a reset-done word can be read.

Read data is registered: a read issued in one cycle returns its value on `bus_rdata_o` after the next rising edge and holds it until the next read.

Top module: `mbx_top`

## Requirements
- R1: A write to byte address 0x40+4q (q = 0..5) stores the word in queue q. A read of that address returns the oldest stored word one cycle later and removes it, so words come out in write order.
- R2: Each queue holds 4 words. A write to a full queue is dropped and leaves the count and stored words unchanged.
- R3: A read of an empty queue's message address returns 0 and leaves its count at 0.
- R4: Address 0x80+4q reads 1 when queue q holds 4 words and 0 otherwise. Address 0xC0+4q reads the number of words waiting in queue q.
- R5: An accepted write to queue q sets bit 2q (new-message event) in the status word of all four users.
- R6: A read that takes queue q from 4 words to 3 sets bit 2q+1 (not-full event) in the status word of all four users.
- R7: User u's status word is at 0x100+8u. Writing 1 to a bit clears it and writing 0 leaves it as it was. An event arriving in the same cycle as a clear wins.
- R8: User u's enable word is at 0x104+8u and reads back the written value in bits 11:0. Output `irq_o[u]` is high while status and enable share a set bit.
- R9: The config word at 0x10 keeps written bits 0 and 4 and reads 0 elsewhere. Address 0x00 reads the revision constant 0x00000021. Address 0x14 reads 1 once a clock edge has passed after reset release.
- R10: A cycle that both writes and reads the message address of a full queue returns the oldest word and stores the new one. The count stays at 4, the new-message event is set and the not-full event is not set.
- R11: Reset empties every queue and clears status, enable, config and read data. Reads of addresses outside the map return 0 and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 9 | Byte address of the access |
| bus_wr_i | input | 1 | Write strobe for this cycle |
| bus_rd_i | input | 1 | Read strobe for this cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 4 | Interrupt line of each user |

## Verification
A removal and a store can hit the same queue in one cycle when a single access asserts both strobes on a message address. The bench fills one queue to four words and clears the acknowledged status. It then issues such a combined access and judges the returned word, the count that stays at four, and the status word, which must show only the new-message event. Dropped writes to a full queue, reads of an empty queue and write-one-to-clear acknowledgement are checked through the count, message and status addresses.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 9;
  localparam int unsigned NUM_Q  = 6;
  localparam int unsigned NUM_U  = 4;
  localparam int unsigned Q_DEPTH = 4;

  localparam logic [ADDR_W-1:0] OFS_REV   = 9'h000;
  localparam logic [ADDR_W-1:0] OFS_CFG   = 9'h010;
  localparam logic [ADDR_W-1:0] OFS_RDONE = 9'h014;
  localparam logic [ADDR_W-1:0] OFS_MSG   = 9'h040;
  localparam logic [ADDR_W-1:0] OFS_FULL  = 9'h080;
  localparam logic [ADDR_W-1:0] OFS_CNT   = 9'h0C0;
  localparam logic [ADDR_W-1:0] OFS_IRQ   = 9'h100;

  typedef enum logic [2:0] {
    RG_NONE, RG_REV, RG_CFG, RG_RDONE, RG_MSG, RG_FULL, RG_CNT, RG_IRQ
  } region_e;

  typedef struct packed {
    region_e    rg;
    logic [3:0] idx;
    logic       sel_en;
  } dec_t;

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int unsigned NQ = NUM_Q,
  parameter int unsigned NU = NUM_U
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);

  always_comb begin
    dec_o = '{rg: RG_NONE, idx: 4'd0, sel_en: 1'b0};
    if (addr_i[1:0] == 2'b00) begin
      if (addr_i == OFS_REV) begin
        dec_o.rg = RG_REV;
      end else if (addr_i == OFS_CFG) begin
        dec_o.rg = RG_CFG;
      end else if (addr_i == OFS_RDONE) begin
        dec_o.rg = RG_RDONE;
      end else if (addr_i[8:6] == OFS_MSG[8:6] && addr_i[5:2] < 4'(NQ)) begin
        dec_o.rg  = RG_MSG;
        dec_o.idx = addr_i[5:2];
      end else if (addr_i[8:6] == OFS_FULL[8:6] && addr_i[5:2] < 4'(NQ)) begin
        dec_o.rg  = RG_FULL;
        dec_o.idx = addr_i[5:2];
      end else if (addr_i[8:6] == OFS_CNT[8:6] && addr_i[5:2] < 4'(NQ)) begin
        dec_o.rg  = RG_CNT;
        dec_o.idx = addr_i[5:2];
      end else if (addr_i[8:5] == OFS_IRQ[8:5] && {2'b00, addr_i[4:3]} < 4'(NU)) begin
        dec_o.rg     = RG_IRQ;
        dec_o.idx    = {2'b00, addr_i[4:3]};
        dec_o.sel_en = addr_i[2];
      end
    end
  end

endmodule

// File: rtl/mbx_queue.sv
module mbx_queue #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          pushed_o,
  output logic          left_full_o
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] count_q, count_d;
  logic          push_ok, pop_ok;

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign count_o = count_q;
  assign head_o  = mem_q[rp_q];

  always_comb begin
    pop_ok  = pop_i && !empty_o;
    push_ok = push_i && (!full_o || pop_ok);
    wp_d    = wp_q;
    rp_d    = rp_q;
    count_d = count_q;
    if (push_ok) wp_d = wp_q + PW'(1);
    if (pop_ok)  rp_d = rp_q + PW'(1);
    case ({push_ok, pop_ok})
      2'b10:   count_d = count_q + CW'(1);
      2'b01:   count_d = count_q - CW'(1);
      default: count_d = count_q;
    endcase
  end

  assign pushed_o    = push_ok;
  assign left_full_o = pop_ok && full_o && !push_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q    <= '0;
      rp_q    <= '0;
      count_q <= '0;
    end else begin
      wp_q    <= wp_d;
      rp_q    <= rp_d;
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wp_q] <= wdata_i;
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));

  // R2
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && full_o) |=> (count_q == CW'(DEPTH)));

  // R3
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && empty_o) |=> (count_q == '0));

  // R10
  both_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && full_o) |=> full_o);

endmodule

// File: rtl/mbx_irq_user.sv
module mbx_irq_user #(
  parameter int unsigned NQ = 6,
  localparam int unsigned SW = 2 * NQ
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] new_ev_i,
  input  logic [NQ-1:0] nf_ev_i,
  input  logic          st_wr_i,
  input  logic          en_wr_i,
  input  logic [SW-1:0] wdata_i,
  output logic [SW-1:0] status_o,
  output logic [SW-1:0] enable_o,
  output logic          irq_o
);

  logic [SW-1:0] ev_vec;
  logic [SW-1:0] status_q, status_d;
  logic [SW-1:0] enable_q, enable_d;

  for (genvar m = 0; m < NQ; m++) begin : g_pack
    assign ev_vec[2*m]   = new_ev_i[m];
    assign ev_vec[2*m+1] = nf_ev_i[m];
  end

  always_comb begin
    status_d = (status_q & ~(st_wr_i ? wdata_i : '0)) | ev_vec;
    enable_d = en_wr_i ? wdata_i : enable_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= status_d;
      enable_q <= enable_d;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign irq_o    = |(status_q & enable_q);

  for (genvar b = 0; b < SW; b++) begin : g_chk
    // R5 R6
    ev_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_vec[b] |=> status_q[b]);

    // R7
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr_i && wdata_i[b] && !ev_vec[b]) |=> !status_q[b]);

    // R7
    w0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr_i && !wdata_i[b] && status_q[b]) |=> status_q[b]);
  end

endmodule

// File: rtl/mbx_top.sv
module mbx_top
  import mbx_pkg::*;
#(
  parameter int unsigned NQ       = NUM_Q,
  parameter int unsigned NU       = NUM_U,
  parameter int unsigned DEPTH    = Q_DEPTH,
  parameter logic [31:0] REVISION = 32'h0000_0021,
  localparam int unsigned SW      = 2 * NQ,
  localparam int unsigned CW      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [NU-1:0]     irq_o
);

  dec_t dec;

  logic [NQ-1:0]     q_push, q_pop, q_full, q_empty, q_pushed, q_left_full;
  logic [DATA_W-1:0] q_head [NQ];
  logic [CW-1:0]     q_cnt  [NQ];

  logic [NU-1:0]     u_st_wr, u_en_wr;
  logic [SW-1:0]     u_status [NU];
  logic [SW-1:0]     u_enable [NU];

  logic [1:0]        cfg_q, cfg_d;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;

  mbx_decode #(.NQ(NQ), .NU(NU)) u_dec (
    .addr_i (bus_addr_i),
    .dec_o  (dec)
  );

  always_comb begin
    q_push  = '0;
    q_pop   = '0;
    u_st_wr = '0;
    u_en_wr = '0;
    for (int i = 0; i < NQ; i++) begin
      if (dec.rg == RG_MSG && dec.idx == 4'(i)) begin
        q_push[i] = bus_wr_i;
        q_pop[i]  = bus_rd_i;
      end
    end
    for (int i = 0; i < NU; i++) begin
      if (dec.rg == RG_IRQ && dec.idx == 4'(i)) begin
        u_st_wr[i] = bus_wr_i && !dec.sel_en;
        u_en_wr[i] = bus_wr_i && dec.sel_en;
      end
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_q
    mbx_queue #(.DW(DATA_W), .DEPTH(DEPTH)) u_queue (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (q_push[q]),
      .pop_i       (q_pop[q]),
      .wdata_i     (bus_wdata_i),
      .head_o      (q_head[q]),
      .count_o     (q_cnt[q]),
      .full_o      (q_full[q]),
      .empty_o     (q_empty[q]),
      .pushed_o    (q_pushed[q]),
      .left_full_o (q_left_full[q])
    );
  end

  for (genvar u = 0; u < NU; u++) begin : g_u
    mbx_irq_user #(.NQ(NQ)) u_user (
      .clk      (clk),
      .rst_n    (rst_n),
      .new_ev_i (q_pushed),
      .nf_ev_i  (q_left_full),
      .st_wr_i  (u_st_wr[u]),
      .en_wr_i  (u_en_wr[u]),
      .wdata_i  (bus_wdata_i[SW-1:0]),
      .status_o (u_status[u]),
      .enable_o (u_enable[u]),
      .irq_o    (irq_o[u])
    );
  end

  always_comb begin
    cfg_d = cfg_q;
    if (bus_wr_i && dec.rg == RG_CFG) cfg_d = {bus_wdata_i[4], bus_wdata_i[0]};
  end

  always_comb begin
    rd_mux = '0;
    case (dec.rg)
      RG_REV:   rd_mux = REVISION;
      RG_CFG:   begin
        rd_mux[0] = cfg_q[0];
        rd_mux[4] = cfg_q[1];
      end
      RG_RDONE: rd_mux[0] = done_q;
      RG_MSG:   begin
        for (int i = 0; i < NQ; i++)
          if (dec.idx == 4'(i) && !q_empty[i]) rd_mux = q_head[i];
      end
      RG_FULL:  begin
        for (int i = 0; i < NQ; i++)
          if (dec.idx == 4'(i)) rd_mux[0] = q_full[i];
      end
      RG_CNT:   begin
        for (int i = 0; i < NQ; i++)
          if (dec.idx == 4'(i)) rd_mux[CW-1:0] = q_cnt[i];
      end
      RG_IRQ:   begin
        for (int i = 0; i < NU; i++)
          if (dec.idx == 4'(i))
            rd_mux[SW-1:0] = dec.sel_en ? u_enable[i] : u_status[i];
      end
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      cfg_q  <= cfg_d;
      done_q <= 1'b1;
      if (bus_rd_i) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata_o = rdata_q;

  // R1
  pop_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop[0] && !q_push[0] && !q_empty[0]) |=> (q_cnt[0] == $past(q_cnt[0]) - CW'(1)));

  // R11
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_i |=> $stable(bus_rdata_o));

endmodule

// File: tb/sim_mbx_top.sv
module sim_mbx_top;

  typedef struct packed {
    logic        rd;
    logic [3:0]  req;
    logic [8:0]  a;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd1,  9'h048, 32'hA1A1_0001, 32'h0},            // R1 push
    '{1'b0, 4'd1,  9'h048, 32'hA1A1_0002, 32'h0},            // R1 push
    '{1'b1, 4'd4,  9'h0C8, 32'h0,         32'h2},            // R4 count
    '{1'b1, 4'd4,  9'h088, 32'h0,         32'h0},            // R4 not full
    '{1'b1, 4'd5,  9'h108, 32'h0,         32'h10},           // R5 user1
    '{1'b1, 4'd5,  9'h100, 32'h0,         32'h10},           // R5 user0
    '{1'b1, 4'd1,  9'h048, 32'h0,         32'hA1A1_0001},    // R1 oldest
    '{1'b1, 4'd1,  9'h048, 32'h0,         32'hA1A1_0002},    // R1 order
    '{1'b1, 4'd3,  9'h048, 32'h0,         32'h0},            // R3 empty read
    '{1'b1, 4'd3,  9'h0C8, 32'h0,         32'h0},            // R3 count 0
    '{1'b0, 4'd7,  9'h108, 32'h0,         32'h0},            // R7 write zero
    '{1'b1, 4'd7,  9'h108, 32'h0,         32'h10},           // R7 kept
    '{1'b0, 4'd7,  9'h108, 32'h10,        32'h0},            // R7 clear
    '{1'b1, 4'd7,  9'h108, 32'h0,         32'h0},            // R7 cleared
    '{1'b0, 4'd8,  9'h10C, 32'hFFFF_FFFF, 32'h0},            // R8 enable
    '{1'b1, 4'd8,  9'h10C, 32'h0,         32'hFFF},          // R8 readback
    '{1'b0, 4'd9,  9'h010, 32'hFFFF_FFFF, 32'h0},            // R9 config
    '{1'b1, 4'd9,  9'h010, 32'h0,         32'h11},           // R9 config bits
    '{1'b1, 4'd9,  9'h014, 32'h0,         32'h1},            // R9 reset done
    '{1'b1, 4'd9,  9'h000, 32'h0,         32'h21},           // R9 revision
    '{1'b1, 4'd11, 9'h03C, 32'h0,         32'h0},            // R11 unmapped
    '{1'b1, 4'd11, 9'h058, 32'h0,         32'h0}             // R11 no queue 6
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  int          checks = 0;
  int          fails = 0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  mbx_top u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr_i  (addr),
    .bus_wr_i    (wr),
    .bus_rd_i    (rd),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input logic w, input logic r, input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr = w; rd = r; wdata = d;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
  endtask

  task automatic rd_chk(input logic [8:0] a, input logic [31:0] e, input string tag);
    bus_op(1'b0, 1'b1, a, 32'h0);
    check(tag, rdata, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset rdata", rdata, 32'h0);
    check("R11 reset irq", {28'h0, irq}, 32'h0);
    rst_n = 1'b1;
    rd_chk(9'h014, 32'h1, "R9 reset-done after release");

    for (int i = 0; i < NV; i++) begin
      bus_op(~VEC[i].rd, VEC[i].rd, VEC[i].a, VEC[i].d);
      if (VEC[i].rd) check($sformatf("R%0d vector %0d", VEC[i].req, i), rdata, VEC[i].e);
    end

    // R2 R6: overfill queue 0
    bus_op(1'b1, 1'b0, 9'h10C, 32'h0);
    for (int u = 0; u < 4; u++) bus_op(1'b1, 1'b0, 9'(9'h100 + 8*u), 32'hFFF);
    for (int k = 0; k < 5; k++) bus_op(1'b1, 1'b0, 9'h040, 32'hB000_0000 + k);
    rd_chk(9'h080, 32'h1, "R4 full flag");
    rd_chk(9'h0C0, 32'h4, "R2 count capped");
    rd_chk(9'h100, 32'h1, "R5 new-message only");
    rd_chk(9'h040, 32'hB000_0000, "R2 first word");
    rd_chk(9'h118, 32'h3, "R6 not-full event user3");
    rd_chk(9'h080, 32'h0, "R4 full cleared");
    for (int k = 1; k < 4; k++) rd_chk(9'h040, 32'hB000_0000 + k, "R2 stored words");
    rd_chk(9'h040, 32'h0, "R2 fifth word dropped");

    // R8: interrupt line
    bus_op(1'b1, 1'b0, 9'h118, 32'hFFF);
    check("R8 irq idle", {28'h0, irq}, 32'h0);
    bus_op(1'b1, 1'b0, 9'h11C, 32'h1);
    bus_op(1'b1, 1'b0, 9'h040, 32'hC0C0_C0C0);
    check("R8 irq user3 raised", {28'h0, irq}, 32'h8);
    bus_op(1'b1, 1'b0, 9'h118, 32'h1);
    check("R8 irq acknowledged", {28'h0, irq}, 32'h0);
    rd_chk(9'h040, 32'hC0C0_C0C0, "R1 single word");

    // R10: simultaneous pop and push on a full queue
    for (int k = 0; k < 4; k++) bus_op(1'b1, 1'b0, 9'h054, 32'hD000_0000 + k);
    bus_op(1'b1, 1'b0, 9'h100, 32'hFFF);
    bus_op(1'b1, 1'b1, 9'h054, 32'hD000_0004);
    check("R10 oldest returned", rdata, 32'hD000_0000);
    rd_chk(9'h0D4, 32'h4, "R10 count stays full");
    rd_chk(9'h100, 32'h400, "R10 events");
    for (int k = 1; k < 5; k++) rd_chk(9'h054, 32'hD000_0000 + k, "R10 order");

    // R11: reset mid-run
    bus_op(1'b1, 1'b0, 9'h044, 32'hE1E1_E1E1);
    bus_op(1'b1, 1'b0, 9'h010, 32'h11);
    bus_op(1'b1, 1'b0, 9'h104, 32'h5);
    bus_op(1'b1, 1'b0, 9'h3F0, 32'hFFFF_FFFF);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    check("R11 irq after reset", {28'h0, irq}, 32'h0);
    rd_chk(9'h0C4, 32'h0, "R11 queue emptied");
    rd_chk(9'h044, 32'h0, "R11 no word left");
    rd_chk(9'h010, 32'h0, "R11 config cleared");
    rd_chk(9'h104, 32'h0, "R11 enable cleared");
    rd_chk(9'h100, 32'h0, "R11 status cleared");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule